// File: doc/BRIEF.md
# Collapsing Issue Queue with Tag Wakeup

The block holds dispatched micro-operations in age order. Entry 0 is always the oldest. Each entry stores its own 8-bit tag and up to four source tags. Each source carries a flag that says whether it is still waiting for a producer. When a producer completes, its tag is broadcast. Every waiting source with a matching tag then stops waiting.

Once per cycle, every occupied entry that is not issued and has no waiting source is latched as ready. The lowest-index ready entry is offered on the issue port. When the scheduler accepts the offer, that entry is marked issued.

An issued entry leaves the queue in one of two ways:
- **Release** removes it. Every younger entry moves down one position, so the free space always sits at the top.
- **Replay** returns it to the waiting state. Replay may also attach new source dependencies.

Top module: `coll_issue_queue`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `full` is 0 and `iss_valid` is 0.
- R2: An accepted insert writes the new entry at position `count` and increments `count`. With `full` high and no release in the same cycle, the insert is ignored and `count` is unchanged.
- R3: Source k of an insert occupies bits `[8k+7:8k]` of `ins_src_tags`. Bit k of `ins_src_wait` set to 1 marks that source as waiting. An entry with no waiting source becomes issuable in the cycle after its insert.
- R4: A broadcast clears the waiting flag of each waiting source whose tag equals `bc_tag`, in every entry, and leaves that entry's other sources unchanged. This includes the entry being inserted in the same cycle.
- R5: `iss_slot` and `iss_tag` give the lowest-index ready entry. When `iss_en` is high while `iss_valid` is high, that entry becomes issued and is not offered again unless it is replayed.
- R6: Replay of position `rpl_slot` clears its issued state. For each set bit k of `rpl_src_wait`, source k takes tag field k of `rpl_src_tags` and becomes waiting. A broadcast in the same cycle does not clear these new dependencies.
- R7: Release of position `rel_slot` removes that entry, moves each higher entry down by one position with its state intact, and decrements `count`.
- R8: When insert and release occur in the same cycle, compaction is applied first. The new entry lands at the old `count` minus one, and `count` is unchanged.
- R9: Readiness is latched from the state that results after all of a cycle's operations. An entry woken or replayed in cycle N can therefore first be offered in cycle N+1.
- R10: `full` is high exactly when `count` equals DEPTH. An issued position index refers to the same entry only until a release at a lower position.

Operation order within one cycle is broadcast, then issue, then replay, then release compaction, then insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_tag | input | TAG_W | Tag of the new entry |
| ins_src_tags | input | NSRC*TAG_W | Source tags, field k for source k |
| ins_src_wait | input | NSRC | Per-source waiting flags |
| bc_valid | input | 1 | Broadcast request |
| bc_tag | input | TAG_W | Completed tag |
| iss_en | input | 1 | Accept the offered entry |
| rpl_valid | input | 1 | Replay request |
| rpl_slot | input | IDX_W | Position to replay |
| rpl_src_wait | input | NSRC | Sources that gain a new dependency |
| rpl_src_tags | input | NSRC*TAG_W | New source tags |
| rel_valid | input | 1 | Release request |
| rel_slot | input | IDX_W | Position to release |
| iss_valid | output | 1 | A ready entry is offered |
| iss_slot | output | IDX_W | Position of the offered entry |
| iss_tag | output | TAG_W | Tag of the offered entry |
| count | output | CNT_W | Occupied positions |
| full | output | 1 | Queue holds DEPTH entries |

## Verification
The properties assume well-formed requests:
- releases and replays name an occupied position that is already issued;
- a replay and a release in the same cycle never name the same position.

The stimulus draws release and replay positions only from the entries that the bench's own model holds as issued. It excludes the position taken by a replay from the release choice. An opening burst of inserts with no issuing drives the queue to full, so the ignored-insert case and the insert-with-release case are both exercised. Source and broadcast tags come from a small range so that wakeups, including same-cycle wakeup of an inserted entry, happen often.

// File: rtl/coll_issue_queue.sv
module coll_issue_queue #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  parameter int NSRC  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  input  logic [TAG_W-1:0]      ins_tag,
  input  logic [NSRC*TAG_W-1:0] ins_src_tags,
  input  logic [NSRC-1:0]       ins_src_wait,
  input  logic                  bc_valid,
  input  logic [TAG_W-1:0]      bc_tag,
  input  logic                  iss_en,
  input  logic                  rpl_valid,
  input  logic [IDX_W-1:0]      rpl_slot,
  input  logic [NSRC-1:0]       rpl_src_wait,
  input  logic [NSRC*TAG_W-1:0] rpl_src_tags,
  input  logic                  rel_valid,
  input  logic [IDX_W-1:0]      rel_slot,
  output logic                  iss_valid,
  output logic [IDX_W-1:0]      iss_slot,
  output logic [TAG_W-1:0]      iss_tag,
  output logic [CNT_W-1:0]      count,
  output logic                  full
);

  logic [TAG_W-1:0]      tag_q [DEPTH];
  logic [NSRC*TAG_W-1:0] src_q [DEPTH];
  logic [NSRC-1:0]       wt_q  [DEPTH];
  logic [DEPTH-1:0]      vld_q, isd_q, rdy_q;

  logic [TAG_W-1:0]      tag_t [DEPTH];
  logic [NSRC*TAG_W-1:0] src_t [DEPTH];
  logic [NSRC-1:0]       wt_t  [DEPTH];
  logic [DEPTH-1:0]      vld_t, isd_t;

  logic [TAG_W-1:0]      tag_n [DEPTH];
  logic [NSRC*TAG_W-1:0] src_n [DEPTH];
  logic [NSRC-1:0]       wt_n  [DEPTH];
  logic [DEPTH-1:0]      vld_n, isd_n, rdy_n;

  logic [CNT_W-1:0] cnt_rel, cnt_n;
  logic             ins_ok;
  logic [NSRC-1:0]  ins_wt;

  assign full      = (count == CNT_W'(DEPTH));
  assign iss_valid = |rdy_q;
  assign iss_tag   = tag_q[iss_slot];
  assign cnt_rel   = count - CNT_W'(rel_valid);
  assign ins_ok    = ins_valid && (cnt_rel < CNT_W'(DEPTH));
  assign cnt_n     = cnt_rel + CNT_W'(ins_ok);

  always_comb begin
    iss_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy_q[i]) iss_slot = IDX_W'(i);
  end

  always_comb begin
    for (int k = 0; k < NSRC; k++)
      ins_wt[k] = ins_src_wait[k] &&
                  !(bc_valid && ins_src_tags[k*TAG_W +: TAG_W] == bc_tag);
  end

  always_comb begin
    vld_t = vld_q;
    isd_t = isd_q;
    for (int i = 0; i < DEPTH; i++) begin
      tag_t[i] = tag_q[i];
      src_t[i] = src_q[i];
      wt_t[i]  = wt_q[i];
      for (int k = 0; k < NSRC; k++)
        if (bc_valid && src_q[i][k*TAG_W +: TAG_W] == bc_tag) wt_t[i][k] = 1'b0;
    end
    if (iss_en && iss_valid) isd_t[iss_slot] = 1'b1;
    if (rpl_valid) begin
      isd_t[rpl_slot] = 1'b0;
      for (int k = 0; k < NSRC; k++)
        if (rpl_src_wait[k]) begin
          wt_t[rpl_slot][k] = 1'b1;
          src_t[rpl_slot][k*TAG_W +: TAG_W] = rpl_src_tags[k*TAG_W +: TAG_W];
        end
    end
  end

  always_comb begin
    vld_n = vld_t;
    isd_n = isd_t;
    for (int i = 0; i < DEPTH; i++) begin
      tag_n[i] = tag_t[i];
      src_n[i] = src_t[i];
      wt_n[i]  = wt_t[i];
    end
    if (rel_valid) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(rel_slot)) begin
          tag_n[i] = tag_t[i+1];
          src_n[i] = src_t[i+1];
          wt_n[i]  = wt_t[i+1];
          vld_n[i] = vld_t[i+1];
          isd_n[i] = isd_t[i+1];
        end
      vld_n[DEPTH-1] = 1'b0;
      isd_n[DEPTH-1] = 1'b0;
      wt_n[DEPTH-1]  = '0;
    end
    for (int i = 0; i < DEPTH; i++)
      if (ins_ok && i == int'(cnt_rel)) begin
        tag_n[i] = ins_tag;
        src_n[i] = ins_src_tags;
        wt_n[i]  = ins_wt;
        vld_n[i] = 1'b1;
        isd_n[i] = 1'b0;
      end
    for (int i = 0; i < DEPTH; i++)
      rdy_n[i] = vld_n[i] && !isd_n[i] && (wt_n[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      isd_q <= '0;
      rdy_q <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        src_q[i] <= '0;
        wt_q[i]  <= '0;
      end
    end else begin
      vld_q <= vld_n;
      isd_q <= isd_n;
      rdy_q <= rdy_n;
      count <= cnt_n;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= tag_n[i];
        src_q[i] <= src_n[i];
        wt_q[i]  <= wt_n[i];
      end
    end
  end

endmodule

// File: rtl/coll_issue_queue_props.sv
module coll_issue_queue_props #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             rel_valid,
  input logic             iss_valid,
  input logic [IDX_W-1:0] iss_slot,
  input logic [CNT_W-1:0] count,
  input logic             full
);

  p_full_ignores_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && ins_valid && !rel_valid |=> $stable(count));

  p_insert_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !rel_valid && !full |=> count == $past(count) + CNT_W'(1));

  p_offer_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> {1'b0, iss_slot} < {1'b0, count});

  p_release_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !ins_valid |=> count == $past(count) - CNT_W'(1));

  p_pair_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && ins_valid |=> $stable(count));

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

bind coll_issue_queue coll_issue_queue_props #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .rel_valid(rel_valid),
  .iss_valid(iss_valid), .iss_slot(iss_slot), .count(count), .full(full)
);

// File: tb/test_coll_issue_queue.sv
module test_coll_issue_queue;
  localparam int DEPTH = 8;
  localparam int TAG_W = 8;
  localparam int NSRC  = 4;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] src [NSRC];
    logic             wt  [NSRC];
    logic             isd;
    logic             rdy;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, bc_valid = 0, iss_en = 0, rpl_valid = 0, rel_valid = 0;
  logic [TAG_W-1:0] ins_tag = 0, bc_tag = 0;
  logic [NSRC*TAG_W-1:0] ins_src_tags = 0, rpl_src_tags = 0;
  logic [NSRC-1:0] ins_src_wait = 0, rpl_src_wait = 0;
  logic [IDX_W-1:0] rpl_slot = 0, rel_slot = 0;
  logic iss_valid, full;
  logic [IDX_W-1:0] iss_slot;
  logic [TAG_W-1:0] iss_tag;
  logic [CNT_W-1:0] count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  ent_t mq[$];

  always #10 clk = ~clk;

  coll_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NSRC(NSRC)) i_coll_issue_queue (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_tag(ins_tag),
    .ins_src_tags(ins_src_tags), .ins_src_wait(ins_src_wait),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .iss_en(iss_en),
    .rpl_valid(rpl_valid), .rpl_slot(rpl_slot), .rpl_src_wait(rpl_src_wait),
    .rpl_src_tags(rpl_src_tags), .rel_valid(rel_valid), .rel_slot(rel_slot),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_tag(iss_tag),
    .count(count), .full(full));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int first = -1;
    foreach (mq[i]) if (mq[i].rdy && first < 0) first = i;
    check("R2/R7/R8 count", int'(count), mq.size());
    check("R10 full", int'(full), int'(mq.size() == DEPTH));
    check("R3/R4/R9 iss_valid", int'(iss_valid), int'(first >= 0));
    if (first >= 0) begin
      check("R5 iss_slot", int'(iss_slot), first);
      check("R5/R6 iss_tag", int'(iss_tag), int'(mq[first].tag));
    end
  endtask

  // Model of one clock: broadcast, issue, replay (R6), release (R7), insert (R8), latch (R9)
  task automatic model_step();
    int sel = -1;
    foreach (mq[i]) if (mq[i].rdy && sel < 0) sel = i;
    foreach (mq[i])
      for (int k = 0; k < NSRC; k++)
        if (bc_valid && mq[i].src[k] == bc_tag) mq[i].wt[k] = 0;
    if (iss_en && sel >= 0) mq[sel].isd = 1;
    if (rpl_valid) begin
      mq[rpl_slot].isd = 0;
      for (int k = 0; k < NSRC; k++)
        if (rpl_src_wait[k]) begin
          mq[rpl_slot].wt[k]  = 1;
          mq[rpl_slot].src[k] = rpl_src_tags[k*TAG_W +: TAG_W];
        end
    end
    if (rel_valid) mq.delete(int'(rel_slot));
    if (ins_valid && mq.size() < DEPTH) begin
      ent_t e;
      e.tag = ins_tag;
      e.isd = 0;
      e.rdy = 0;
      for (int k = 0; k < NSRC; k++) begin
        e.src[k] = ins_src_tags[k*TAG_W +: TAG_W];
        e.wt[k]  = ins_src_wait[k] && !(bc_valid && e.src[k] == bc_tag); // R4 same-cycle
      end
      mq.push_back(e);
    end
    foreach (mq[i]) begin
      bit w = 0;
      for (int k = 0; k < NSRC; k++) w |= mq[i].wt[k];
      mq[i].rdy = !mq[i].isd && !w;
    end
  endtask

  task automatic pick(int cyc);
    int issued_idx[$];
    foreach (mq[i]) if (mq[i].isd) issued_idx.push_back(i);
    ins_valid = (cyc < 30) ? 1'b1 : ($urandom_range(0, 99) < 55);
    ins_tag = TAG_W'($urandom);
    for (int k = 0; k < NSRC; k++)
      ins_src_tags[k*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 7));
    ins_src_wait = NSRC'($urandom);
    bc_valid = ($urandom_range(0, 99) < 60);
    bc_tag = TAG_W'($urandom_range(0, 7));
    iss_en = (cyc < 30) ? 1'b0 : ($urandom_range(0, 99) < 75);
    rpl_valid = 0;
    rel_valid = 0;
    if (issued_idx.size() > 0 && $urandom_range(0, 99) < 15) begin
      rpl_valid = 1;
      rpl_slot = IDX_W'(issued_idx[$urandom_range(0, issued_idx.size() - 1)]);
      rpl_src_wait = NSRC'($urandom);
      for (int k = 0; k < NSRC; k++)
        rpl_src_tags[k*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 7));
    end
    if (issued_idx.size() > 0 && $urandom_range(0, 99) < 45) begin
      int c = issued_idx[$urandom_range(0, issued_idx.size() - 1)];
      if (!(rpl_valid && c == int'(rpl_slot))) begin
        rel_valid = 1;
        rel_slot = IDX_W'(c);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", int'(count), 0);
    check("R1 full", int'(full), 0);
    check("R1 iss_valid", int'(iss_valid), 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      compare_all();
      pick(cyc);
      model_step();
      @(negedge clk);
    end
    compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule